// File: doc/BRIEF.md
# Synthesiser Programming Slave over I2C

This block is the two-wire serial slave that programs a PLL frequency synthesiser and reports its status. A controller addresses it with a 7-bit address, and two of those bits come from pins. In write mode the controller sends data bytes in pairs. The first bit of the opening byte of each pair picks the target. A 0 starts a 15-bit divider word. A 1 starts a pair of control bytes that carry the reference ratio, test mode, charge-pump current, reference-output controls and four port states. In read mode the slave returns a status byte that carries a power-on flag and a lock flag.

The divider word changes only as a whole. Its upper part waits in a holding register until the lower byte arrives, or until a STOP commits it next to the old lower byte. Pairs may follow one another without a new address. The serial lines are oversampled by the system clock through two-stage synchronisers. START and STOP are SDA edges seen while SCL is high.

Top module: `synth_ctl_i2c`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1,1,0,0,0,addr_sel[1],addr_sel[0]. Bit 0 of that byte selects write (0) or read (1). For any other address SDA stays released for the rest of the transfer.
- R2: In write mode, a pair whose first byte has bit 7 = 0 carries divider bits 14..8 in bits 6..0 of that byte and bits 7..0 in the second byte. freq_word takes the new value only once the second byte is complete, and it is unchanged between the two bytes.
- R3: A pair whose first byte has bit 7 = 1 sets test_mode[2:0] from bits 6..4 and ref_div[3:0] from bits 3..0 of that byte. The second byte sets cp_cur[1:0] from bits 7..6, ref_out_en from bit 5, ref_out_sel from bit 4 and port_on[3:0] from bits 3..0. Each byte takes effect at its own acknowledge.
- R4: Pairs of either kind may follow each other in one transfer without a new address. The pairing restarts at each START or STOP.
- R5: A STOP that arrives while a divider upper byte is held commits freq_word as the held bits 14..8 with the previous bits 7..0. Any byte cut short by a STOP or START has no effect.
- R6: The slave pulls SDA low in the acknowledge slot of every data byte it receives in write mode.
- R7: The status byte is {por, fl, 6'b0}, sent most significant bit first. The por flag is 1 after reset and after a por_evt pulse. It is cleared by a STOP that ends a transfer in which a status byte was sent.
- R8: If the controller does not acknowledge a status byte, the slave releases SDA and sends no more data until the next START.
- R9: The lock flag reported is lock_i, except for these test_mode values: 3'b100 and 3'b101 report 0, and 3'b110 reports 1.
- R10: With test_mode = 3'b111, port_on[0] follows pd_half. With any other test_mode it shows the programmed port bit 0.
- R11: After reset, freq_word, ref_div, cp_cur, test_mode and port_on are 0 (all ports off, high impedance), ref_out_en and ref_out_sel are 1, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_sel | input | 2 | Variable low bits of the slave address |
| lock_i | input | 1 | Phase-lock indication from the loop |
| por_evt | input | 1 | Supply-drop event, sets the por flag |
| pd_half | input | 1 | Divider output over two, for the test route to port 0 |
| freq_word | output | 15 | Programmable divider ratio |
| ref_div | output | 4 | Reference division ratio select |
| cp_cur | output | 2 | Charge-pump current select |
| ref_out_en | output | 1 | Reference/comparison output enable |
| ref_out_sel | output | 1 | 1 selects comparison, 0 reference frequency |
| test_mode | output | 3 | Test mode code |
| port_on | output | 4 | Port switch states, 1 = sinking |

## Verification
Most internal faults show up at the ports within one byte time. A wrong pairing state makes the next byte land in the wrong field, and that shows at the next acknowledge. A lost held upper byte shows up as a wrong freq_word right after the STOP. A stuck por or a wrong lock override shows up in the first status byte read back. The bench mixes these directed cases with random sequences of pairs and STOPs, including STOPs after one byte. After each byte it compares all programmed outputs with a model, so a divergence is caught at the byte that causes it.

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c #(
  parameter logic [4:0] ADDR_HI = 5'b11000,
  parameter int         FW      = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [1:0]    addr_sel,
  input  logic          lock_i,
  input  logic          por_evt,
  input  logic          pd_half,
  output logic [FW-1:0] freq_word,
  output logic [3:0]    ref_div,
  output logic [1:0]    cp_cur,
  output logic          ref_out_en,
  output logic          ref_out_sel,
  output logic [2:0]    test_mode,
  output logic [3:0]    port_on
);
  localparam int HW = FW - 8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WR, S_RD, S_SKIP} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  st_t           st;
  logic [3:0]    bitcnt;
  logic [7:0]    sr, tx;
  logic          ack_drv, rd_drv, second, is_ctrl, fpend, rd_seen, por_q;
  logic [HW-1:0] fhi;
  logic [3:0]    port_q;
  logic          fl_eff;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  always_comb begin
    case (test_mode)
      3'b100, 3'b101: fl_eff = 1'b0;
      3'b110:         fl_eff = 1'b1;
      default:        fl_eff = lock_i;
    endcase
  end

  assign sda_oe  = ack_drv | (rd_drv & ~tx[7]);
  assign port_on = {port_q[3:1], (test_mode == 3'b111) ? pd_half : port_q[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bitcnt      <= '0;
      sr          <= '0;
      tx          <= '0;
      ack_drv     <= 1'b0;
      rd_drv      <= 1'b0;
      second      <= 1'b0;
      is_ctrl     <= 1'b0;
      fpend       <= 1'b0;
      rd_seen     <= 1'b0;
      por_q       <= 1'b1;
      fhi         <= '0;
      freq_word   <= '0;
      ref_div     <= '0;
      cp_cur      <= '0;
      ref_out_en  <= 1'b1;
      ref_out_sel <= 1'b1;
      test_mode   <= '0;
      port_q      <= '0;
    end else begin
      if (start_det) begin
        st      <= S_ADDR;
        bitcnt  <= '0;
        ack_drv <= 1'b0;
        rd_drv  <= 1'b0;
        second  <= 1'b0;
        rd_seen <= 1'b0;
      end else if (stop_det) begin
        st      <= S_IDLE;
        bitcnt  <= '0;
        ack_drv <= 1'b0;
        rd_drv  <= 1'b0;
        second  <= 1'b0;
        rd_seen <= 1'b0;
        if (fpend) begin
          freq_word <= {fhi, freq_word[7:0]};
          fpend     <= 1'b0;
        end
        if (rd_seen) por_q <= 1'b0;
      end else if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          sr     <= {sr[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (st == S_RD && sda_s) st <= S_SKIP;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (st)
            S_ADDR: begin
              if (sr[7:1] == {ADDR_HI, addr_sel}) ack_drv <= 1'b1;
              else st <= S_SKIP;
            end
            S_WR: begin
              ack_drv <= 1'b1;
              if (!second) begin
                second  <= 1'b1;
                is_ctrl <= sr[7];
                if (sr[7]) begin
                  test_mode <= sr[6:4];
                  ref_div   <= sr[3:0];
                end else begin
                  fhi   <= sr[HW-1:0];
                  fpend <= 1'b1;
                end
              end else begin
                second <= 1'b0;
                if (is_ctrl) begin
                  {cp_cur, ref_out_en, ref_out_sel, port_q} <= sr;
                end else begin
                  freq_word <= {fhi, sr};
                  fpend     <= 1'b0;
                end
              end
            end
            S_RD: rd_drv <= 1'b0;
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt  <= '0;
          ack_drv <= 1'b0;
          if (st == S_ADDR) st <= sr[0] ? S_RD : S_WR;
          if ((st == S_ADDR && sr[0]) || st == S_RD) begin
            tx      <= {por_q, fl_eff, 6'b0};
            rd_drv  <= 1'b1;
            rd_seen <= 1'b1;
          end
        end else if (st == S_RD && bitcnt != 4'd0) begin
          tx <= {tx[6:0], 1'b0};
        end
      end
      if (por_evt) por_q <= 1'b1;
    end
  end
endmodule

// File: rtl/synth_ctl_i2c_chk.sv
module synth_ctl_i2c_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        scl_fall,
  input logic        stop_det,
  input logic        sda_oe,
  input logic        rd_drv,
  input logic        tx6,
  input logic [2:0]  st,
  input logic        por_q,
  input logic [14:0] freq_word,
  input logic [2:0]  test_mode
);
  // R6
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R2
  freq_commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_word != $past(freq_word)) |-> ($past(scl_fall) || $past(stop_det)));

  // R7
  por_clear_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(stop_det));

  // R8
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4) |-> !sda_oe);

  // R9
  fl_force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_drv) && $past(test_mode) == 3'b110) |-> tx6);

  // R9
  fl_force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_drv) && $past(test_mode[2:1]) == 2'b10) |-> !tx6);
endmodule

bind synth_ctl_i2c synth_ctl_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .stop_det(stop_det), .sda_oe(sda_oe), .rd_drv(rd_drv), .tx6(tx[6]),
  .st(st), .por_q(por_q), .freq_word(freq_word), .test_mode(test_mode)
);

// File: tb/synth_ctl_i2c_bench.sv
module synth_ctl_i2c_bench;
  localparam int Q = 8;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic [1:0] addr_sel = 2'b01;
  logic lock_i = 1, por_evt = 0, pd_half = 0;
  logic sda_oe;
  logic [14:0] freq_word;
  logic [3:0] ref_div, port_on;
  logic [1:0] cp_cur;
  logic ref_out_en, ref_out_sel;
  logic [2:0] test_mode;
  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  synth_ctl_i2c u_synth_ctl_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .por_evt(por_evt), .pd_half(pd_half),
    .freq_word(freq_word), .ref_div(ref_div), .cp_cur(cp_cur),
    .ref_out_en(ref_out_en), .ref_out_sel(ref_out_sel),
    .test_mode(test_mode), .port_on(port_on)
  );

  int checks = 0, errors = 0;
  logic [14:0] m_freq = 0;
  logic [6:0] m_fhi = 0;
  logic m_pend = 0, m_second = 0, m_ctrl = 0, m_rdseen = 0, m_por = 1;
  logic [2:0] m_test = 0;
  logic [3:0] m_rdiv = 0, m_port = 0;
  logic [1:0] m_cp = 0;
  logic m_re = 1, m_rs = 1;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic exp_fl();
    case (m_test)
      3'b100, 3'b101: return 1'b0;
      3'b110:         return 1'b1;
      default:        return lock_i;
    endcase
  endfunction

  function automatic logic [29:0] exp_outs();
    logic p0;
    p0 = (m_test == 3'b111) ? pd_half : m_port[0];
    return {m_freq, m_rdiv, m_cp, m_re, m_rs, m_test, m_port[3:1], p0};
  endfunction

  function automatic logic [29:0] got_outs();
    return {freq_word, ref_div, cp_cur, ref_out_en, ref_out_sel, test_mode, port_on};
  endfunction

  task automatic m_byte(input logic [7:0] v);
    if (!m_second) begin
      m_second = 1; m_ctrl = v[7];
      if (v[7]) {m_test, m_rdiv} = v[6:0];
      else begin m_fhi = v[6:0]; m_pend = 1; end
    end else begin
      m_second = 0;
      if (m_ctrl) {m_cp, m_re, m_rs, m_port} = v;
      else begin m_freq = {m_fhi, v}; m_pend = 0; end
    end
  endtask

  task automatic qwait();
    repeat (Q) @(posedge clk);
    #2;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1; qwait(); qwait(); scl_m = 0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1; qwait(); scl_m = 1; qwait(); b = sda_bus; qwait(); scl_m = 0; qwait();
  endtask

  task automatic i2c_start();
    sda_m = 1; qwait(); scl_m = 1; qwait(); sda_m = 0; qwait(); scl_m = 0; qwait();
    m_second = 0; m_rdseen = 0;
  endtask

  task automatic i2c_stop();
    sda_m = 0; qwait(); scl_m = 1; qwait(); sda_m = 1; qwait(); qwait();
    if (m_pend) begin m_freq = {m_fhi, m_freq[7:0]}; m_pend = 0; end
    m_second = 0;
    if (m_rdseen) m_por = 0;
    m_rdseen = 0;
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic wdata(input logic [7:0] v, input string req);
    logic ack;
    wbyte(v, ack);
    m_byte(v);
    check("R6 data ack", ack, 1);
    check(req, got_outs(), exp_outs());
  endtask

  task automatic rbyte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~mack);
    m_rdseen = 1;
  endtask

  task automatic addr(input logic rw, input logic exp_ack, input string req);
    logic ack;
    wbyte({5'b11000, addr_sel, rw}, ack);
    check(req, ack, exp_ack);
  endtask

  task automatic read_status(input string req);
    logic [7:0] v, e;
    i2c_start();
    addr(1, 1, "R1 read address ack");
    e = {m_por, exp_fl(), 6'b0};
    rbyte(v, 0);
    check(req, v, e);
    i2c_stop();
  endtask

  task automatic wr_ctrl(input logic [7:0] b4, input logic [7:0] b5);
    i2c_start();
    addr(0, 1, "R1 write address ack");
    wdata(b4, "R3 byte4");
    wdata(b5, "R3 byte5");
    i2c_stop();
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    logic [7:0] b;
    void'($urandom(32'h5eed));
    repeat (5) @(posedge clk);
    #2;
    check("R11 reset outputs", got_outs(), exp_outs());
    check("R11 sda released", sda_oe, 0);
    rst_n = 1;
    qwait();

    // R1 wrong address
    i2c_start();
    wbyte({5'b11000, ~addr_sel, 1'b0}, ack);
    check("R1 wrong address nack", ack, 0);
    wbyte(8'h15, ack);
    check("R1 no ack after wrong address", ack, 0);
    i2c_stop();
    check("R1 outputs untouched", got_outs(), exp_outs());

    // R2 R3 R4 pairs in one transfer
    i2c_start();
    addr(0, 1, "R1 write address ack");
    wdata(8'h55, "R2 freq held after byte2");
    check("R2 freq unchanged mid pair", freq_word, 15'h0);
    wdata(8'hC3, "R2 freq commit");
    wdata({1'b1, 3'b010, 4'b1001}, "R3 byte4 applied");
    wdata(8'hA5, "R3 byte5 applied");
    wdata(8'h2A, "R4 second freq pair byte2");
    wdata(8'h3C, "R4 second freq pair byte3");
    i2c_stop();
    check("R4 final outputs", got_outs(), exp_outs());

    // R5 stop after byte2
    i2c_start();
    addr(0, 1, "R1 write address ack");
    wdata(8'h12, "R2 hold before stop");
    i2c_stop();
    check("R5 stop commits upper with old lower", freq_word, {7'h12, 8'h3C});

    // R5 stop part-way through byte3
    i2c_start();
    addr(0, 1, "R1 write address ack");
    wdata(8'h33, "R2 hold before partial");
    send_bit(1); send_bit(0); send_bit(1);
    i2c_stop();
    check("R5 partial byte dropped", freq_word, {7'h33, 8'h3C});

    // R7 status and por
    lock_i = 1;
    read_status("R7 status after reset");
    read_status("R7 por cleared by stop");
    por_evt = 1; @(posedge clk); #2; por_evt = 0; m_por = 1;
    lock_i = 0;
    read_status("R7 por set by event");

    // R7 two status bytes, R8 nack ends data
    lock_i = 1;
    i2c_start();
    addr(1, 1, "R1 read address ack");
    rbyte(v, 1);
    check("R7 first of two", v, {m_por, 1'b1, 6'b0});
    rbyte(v, 0);
    check("R7 second of two", v, {m_por, 1'b1, 6'b0});
    i2c_stop();
    lock_i = 0;
    i2c_start();
    addr(1, 1, "R1 read address ack");
    rbyte(v, 0);
    check("R7 status zero", v, 8'h00);
    rbyte(v, 0);
    check("R8 released after nack", v, 8'hFF);
    i2c_stop();

    // R9 test modes
    lock_i = 1;
    wr_ctrl({1'b1, 3'b100, 4'h3}, 8'h30);
    read_status("R9 sink forces fl low");
    wr_ctrl({1'b1, 3'b101, 4'h3}, 8'h30);
    read_status("R9 source forces fl low");
    lock_i = 0;
    wr_ctrl({1'b1, 3'b110, 4'h3}, 8'h30);
    read_status("R9 disable forces fl high");
    wr_ctrl({1'b1, 3'b011, 4'h3}, 8'h30);
    read_status("R9 normal reports lock");

    // R10 test route to port 0
    wr_ctrl({1'b1, 3'b111, 4'h7}, 8'h3A);
    pd_half = 1; @(posedge clk); #2;
    check("R10 p0 follows pd_half high", port_on, 4'b1011);
    pd_half = 0; @(posedge clk); #2;
    check("R10 p0 follows pd_half low", port_on, 4'b1010);
    wr_ctrl({1'b1, 3'b000, 4'h7}, 8'h3B);
    pd_half = 0; @(posedge clk); #2;
    check("R10 p0 programmed", port_on, 4'b1011);

    // random pairs and stops, R2 R3 R4 R5
    for (int it = 0; it < 30; it++) begin
      i2c_start();
      addr(0, 1, "R1 write address ack");
      for (int k = 0; k < 1 + ($urandom % 4); k++) begin
        b = 8'($urandom);
        wdata(b, "R4 random first byte");
        if (($urandom % 4) == 0) break;
        b = 8'($urandom);
        wdata(b, "R4 random second byte");
      end
      i2c_stop();
      check("R5 random after stop", got_outs(), exp_outs());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule